// File: doc/BRIEF.md
# Ping-pong wide operand register with word select

This block sits between a wide level-1 scratchpad and a narrow datapath. It holds two line-wide registers. At any time one of them is the *front* bank, which feeds the datapath, and the other is the *back* bank, which accepts the next line from memory. A whole scratchpad line of `NWORDS * WORD_W` bits (10 x 96 = 960 bits by default) lands in the back bank in one transfer, with no per-word decoding. The front bank uses the same storage as a register file of `NWORDS` datapath words. It presents a single operand through a multiplexer, and the select of that multiplexer is driven by an inner loop counter.

A swap exchanges the two roles on one clock edge. Software fills the back bank while the datapath consumes the front bank, so a slow non-volatile read of several cycles stays hidden behind computation. If a swap is requested before the back bank has been filled, the request is held, and the datapath is stalled with `opnd_ok` low until the line arrives. The datapath can write a result into one word slot of the front bank. The whole front line, including those updates, is offered for a store back to memory.

The load port is a valid/ready stream. A line transfers on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is low whenever the back bank already holds an unconsumed line, and the source must then hold its line and retry. The spill port has no back-pressure. `spill_line` stays stable until the next accepted write-back or swap, so the store engine may take it at its own pace while `spill_valid` is high. Swap, select and write-back are plain control pins.

Top module: `vwr_pair`

## Requirements
- R1: After reset both banks are empty and hold zero: `opnd_ok`=0, `ld_ready`=1, `spill_valid`=0 and `rd_word`=0.
- R2: A line is accepted on an edge with `ld_valid` and `ld_ready` both high, and it lands in the back bank whole. From the next cycle `ld_ready` is 0 until a swap empties the back bank.
- R3: A swap requested while the back bank is full takes effect on that edge. In the next cycle the loaded line is the front, `opnd_ok`=1 and `ld_ready`=1.
- R4: A swap requested while the back bank is empty is held pending and `opnd_ok` reads 0. The swap executes on the edge after the load edge, and `opnd_ok` returns to 1 in the cycle after that.
- R5: `rd_word` is the front word numbered `rd_sel`. Word i occupies bits [i*WORD_W+WORD_W-1 : i*WORD_W] of the line.
- R6: With `rd_sel` >= `NWORDS`, `rd_word` is zero and `rd_err` is 1. Otherwise `rd_err` is 0.
- R7: With `wb_valid`=1, `opnd_ok`=1 and `wb_sel` < `NWORDS`, front word `wb_sel` becomes `wb_word` from the next cycle. All other words are unchanged.
- R8: A write-back with `wb_sel` >= `NWORDS`, or one issued while `opnd_ok`=0, changes nothing.
- R9: `spill_valid` = `spill_req` AND `opnd_ok`. `spill_line` is the whole front line, including accepted write-backs.
- R10: `ld_valid` while `ld_ready`=0 is ignored: the back bank keeps its earlier line.
- R11: A load into the back bank leaves every front word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Line offered from the scratchpad |
| ld_ready | output | 1 | Back bank empty, line can be taken |
| ld_line | input | NWORDS*WORD_W | Wide line from the scratchpad |
| swap | input | 1 | Request to exchange front and back roles |
| rd_sel | input | $clog2(NWORDS) | Operand word select (loop index) |
| rd_word | output | WORD_W | Selected front word |
| rd_err | output | 1 | Select out of range |
| opnd_ok | output | 1 | Front valid and no swap pending |
| wb_valid | input | 1 | Write-back word present |
| wb_sel | input | $clog2(NWORDS) | Write-back slot |
| wb_word | input | WORD_W | Write-back data |
| spill_req | input | 1 | Store engine wants the front line |
| spill_valid | output | 1 | Front line may be stored |
| spill_line | output | NWORDS*WORD_W | Whole front line |

## Verification
The hardest situation to reach is a stalled swap that is still pending, with the datapath attempting a write-back, followed by a load that arrives late and releases the stall. The load edge and the swap edge are one cycle apart, and `opnd_ok` must stay low across both. The stimulus requests the swap with the back bank empty and waits several idle cycles. It issues a write-back during the stall and confirms the front word did not change. It then loads a line and samples `opnd_ok` after the load edge and again after the following edge, expecting 0 and then 1.

// File: rtl/vwr_pkg.sv
package vwr_pkg;
  localparam int unsigned N_BANKS = 2;
  typedef logic bank_id_t;

  function automatic bank_id_t partner(bank_id_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/vwr_bank.sv
module vwr_bank #(
  parameter int unsigned WORD_W = 96,
  parameter int unsigned NWORDS = 10,
  localparam int unsigned SEL_W  = $clog2(NWORDS),
  localparam int unsigned LINE_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [LINE_W-1:0] load_line,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_slot,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              clr_full,
  output logic [LINE_W-1:0] line,
  output logic              full
);
  logic [LINE_W-1:0] data_q;
  logic              full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (load_en) begin
        data_q <= load_line;
      end else if (wr_en) begin
        for (int i = 0; i < int'(NWORDS); i++) begin
          if (wr_slot == SEL_W'(i)) data_q[i*WORD_W +: WORD_W] <= wr_word;
        end
      end
      if (load_en)       full_q <= 1'b1;
      else if (clr_full) full_q <= 1'b0;
    end
  end

  assign line = data_q;
  assign full = full_q;
endmodule

// File: rtl/vwr_word_mux.sv
module vwr_word_mux #(
  parameter int unsigned WORD_W = 96,
  parameter int unsigned NWORDS = 10,
  localparam int unsigned SEL_W  = $clog2(NWORDS),
  localparam int unsigned LINE_W = WORD_W * NWORDS
) (
  input  logic [LINE_W-1:0] line,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] word,
  output logic              bad
);
  always_comb begin
    word = '0;
    for (int i = 0; i < int'(NWORDS); i++) begin
      if (sel == SEL_W'(i)) word = line[i*WORD_W +: WORD_W];
    end
    bad = !({1'b0, sel} < (SEL_W+1)'(NWORDS));
  end
endmodule

// File: rtl/vwr_swap_ctl.sv
module vwr_swap_ctl
  import vwr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     swap,
  input  logic     back_full,
  input  logic     front_full,
  output bank_id_t front_id,
  output logic     do_swap,
  output logic     opnd_ok
);
  logic     pend_q;
  bank_id_t front_q;
  logic     want;

  assign want    = swap | pend_q;
  assign do_swap = want & back_full;
  assign opnd_ok = front_full & ~pend_q;
  assign front_id = front_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      front_q <= 1'b0;
    end else begin
      pend_q <= want & ~back_full;
      if (do_swap) front_q <= partner(front_q);
    end
  end
endmodule

// File: rtl/vwr_pair.sv
module vwr_pair
  import vwr_pkg::*;
#(
  parameter int unsigned WORD_W = 96,
  parameter int unsigned NWORDS = 10,
  localparam int unsigned SEL_W  = $clog2(NWORDS),
  localparam int unsigned LINE_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [LINE_W-1:0] ld_line,
  input  logic              swap,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_err,
  output logic              opnd_ok,
  input  logic              wb_valid,
  input  logic [SEL_W-1:0]  wb_sel,
  input  logic [WORD_W-1:0] wb_word,
  input  logic              spill_req,
  output logic              spill_valid,
  output logic [LINE_W-1:0] spill_line
);
  logic [LINE_W-1:0] bank_line [N_BANKS];
  logic              bank_full [N_BANKS];
  bank_id_t          front_id, back_id;
  logic              do_swap, ld_take, wb_take, wb_slot_ok;
  logic [LINE_W-1:0] front_line;

  assign back_id    = partner(front_id);
  assign front_line = bank_line[front_id];
  assign ld_ready   = ~bank_full[back_id];
  assign ld_take    = ld_valid & ld_ready;
  assign wb_slot_ok = {1'b0, wb_sel} < (SEL_W+1)'(NWORDS);
  assign wb_take    = wb_valid & opnd_ok & wb_slot_ok;

  vwr_swap_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .swap       (swap),
    .back_full  (bank_full[back_id]),
    .front_full (bank_full[front_id]),
    .front_id   (front_id),
    .do_swap    (do_swap),
    .opnd_ok    (opnd_ok)
  );

  for (genvar b = 0; b < int'(N_BANKS); b++) begin : g_bank
    logic is_front;
    assign is_front = (front_id == bank_id_t'(b));
    vwr_bank #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (ld_take & ~is_front),
      .load_line (ld_line),
      .wr_en     (wb_take & is_front),
      .wr_slot   (wb_sel),
      .wr_word   (wb_word),
      .clr_full  (do_swap & is_front),
      .line      (bank_line[b]),
      .full      (bank_full[b])
    );
  end

  vwr_word_mux #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_mux (
    .line (front_line),
    .sel  (rd_sel),
    .word (rd_word),
    .bad  (rd_err)
  );

  assign spill_valid = spill_req & opnd_ok;
  assign spill_line  = front_line;
endmodule

// File: rtl/vwr_pair_chk.sv
module vwr_pair_chk #(
  parameter int unsigned WORD_W = 96,
  parameter int unsigned NWORDS = 10,
  localparam int unsigned SEL_W  = $clog2(NWORDS),
  localparam int unsigned LINE_W = WORD_W * NWORDS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic              swap,
  input logic [WORD_W-1:0] rd_word,
  input logic              rd_err,
  input logic              opnd_ok,
  input logic              wb_valid,
  input logic [SEL_W-1:0]  wb_sel,
  input logic              spill_req,
  input logic              spill_valid,
  input logic [LINE_W-1:0] spill_line
);
  p_ldfull_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> !ld_ready);

  p_swap_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !ld_ready) |=> (opnd_ok && ld_ready));

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && ld_ready) |=> !opnd_ok);

  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_word == '0));

  p_spill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spill_valid |-> (opnd_ok && spill_req));

  // R8 and R11: without a legal write-back or a swap, the front line holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_ok && !swap && !(wb_valid && ({1'b0, wb_sel} < (SEL_W+1)'(NWORDS))))
    |=> $stable(spill_line));
endmodule

bind vwr_pair vwr_pair_chk #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .swap(swap), .rd_word(rd_word), .rd_err(rd_err), .opnd_ok(opnd_ok),
  .wb_valid(wb_valid), .wb_sel(wb_sel), .spill_req(spill_req),
  .spill_valid(spill_valid), .spill_line(spill_line)
);

// File: tb/vwr_pair_test.sv
module vwr_pair_test;
  localparam int unsigned WORD_W = 96;
  localparam int unsigned NWORDS = 10;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned LINE_W = WORD_W * NWORDS;

  logic clk = 1'b0;
  logic rst_n, ld_valid, ld_ready, swap, rd_err, opnd_ok;
  logic wb_valid, spill_req, spill_valid;
  logic [LINE_W-1:0] ld_line, spill_line;
  logic [SEL_W-1:0]  rd_sel, wb_sel;
  logic [WORD_W-1:0] rd_word, wb_word;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  vwr_pair #(.WORD_W(WORD_W), .NWORDS(NWORDS)) uut (.*);

  function automatic logic [WORD_W-1:0] pat(int tag, int i);
    return {32'(tag * 1000 + i), 32'hC0DE_0000 + 32'(i), 32'(tag) ^ 32'h5A5A_5A5A};
  endfunction

  function automatic logic [LINE_W-1:0] line_of(int tag);
    logic [LINE_W-1:0] l;
    for (int i = 0; i < int'(NWORDS); i++) l[i*WORD_W +: WORD_W] = pat(tag, i);
    return l;
  endfunction

  task automatic chk(string req, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  localparam int NV = 14;
  localparam logic [3:0] V_SEL [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6,
                                        4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd15, 4'd5};
  localparam logic       V_ERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                        1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [LINE_W-1:0] front;
    logic [WORD_W-1:0] xw;
    rst_n = 0; ld_valid = 0; ld_line = '0; swap = 0; rd_sel = '0;
    wb_valid = 0; wb_sel = '0; wb_word = '0; spill_req = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 opnd_ok", LINE_W'(opnd_ok), '0);
    chk("R1 ld_ready", LINE_W'(ld_ready), LINE_W'(1));
    chk("R1 spill_valid", LINE_W'(spill_valid), '0);
    chk("R1 rd_word", LINE_W'(rd_word), '0);

    ld_valid = 1; ld_line = line_of(1);
    step();
    ld_line = line_of(7);
    chk("R2 ld_ready low", LINE_W'(ld_ready), '0);
    step();               // R10: offered line 7 while not ready
    ld_valid = 0;
    swap = 1;
    step();
    swap = 0;
    chk("R3 opnd_ok", LINE_W'(opnd_ok), LINE_W'(1));
    chk("R3 ld_ready", LINE_W'(ld_ready), LINE_W'(1));
    chk("R10 front is first line", spill_line, line_of(1));

    // R5 / R6 vector walk
    for (int v = 0; v < NV; v++) begin
      rd_sel = V_SEL[v]; #1;
      chk("R5 R6 rd_word", LINE_W'(rd_word), V_ERR[v] ? '0 : LINE_W'(pat(1, int'(V_SEL[v]))));
      chk("R6 rd_err", LINE_W'(rd_err), LINE_W'(V_ERR[v]));
    end

    ld_valid = 1; ld_line = line_of(2);
    step();
    ld_valid = 0;
    chk("R11 front after load", spill_line, line_of(1));

    xw = {3{32'hFEED_BEEF}};
    wb_valid = 1; wb_sel = 4'd4; wb_word = xw;
    step();
    wb_valid = 0;
    front = line_of(1); front[4*WORD_W +: WORD_W] = xw;
    rd_sel = 4'd4; #1;
    chk("R7 slot written", LINE_W'(rd_word), LINE_W'(xw));
    chk("R7 others kept", spill_line, front);
    chk("R9 spill_valid", LINE_W'(spill_valid), LINE_W'(1));
    spill_req = 0; #1;
    chk("R9 spill_valid no req", LINE_W'(spill_valid), '0);
    spill_req = 1;

    wb_valid = 1; wb_sel = 4'd12; wb_word = '1;
    step();
    wb_valid = 0;
    chk("R8 bad slot ignored", spill_line, front);

    swap = 1;
    step();
    swap = 0;
    chk("R3 second swap", spill_line, line_of(2));

    swap = 1;             // back empty now
    step();
    swap = 0;
    chk("R4 stalled", LINE_W'(opnd_ok), '0);
    chk("R4 spill blocked", LINE_W'(spill_valid), '0);
    wb_valid = 1; wb_sel = 4'd0; wb_word = '1;
    step();
    wb_valid = 0;
    rd_sel = 4'd0; #1;
    chk("R8 wb during stall", LINE_W'(rd_word), LINE_W'(pat(2, 0)));
    chk("R4 still stalled", LINE_W'(opnd_ok), '0);
    ld_valid = 1; ld_line = line_of(3);
    step();
    ld_valid = 0;
    chk("R4 stall after load edge", LINE_W'(opnd_ok), '0);
    step();
    chk("R4 released", LINE_W'(opnd_ok), LINE_W'(1));
    chk("R4 new front", spill_line, line_of(3));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule